// File: doc/BRIEF.md
# GCM Nonce Builder with Uniqueness Gate

This block builds the 96-bit initialization vector handed to a GCM cipher core. Each IV joins a 32-bit per-context prefix in the upper bits with a 64-bit value in the lower bits. The requester chooses the mode, and the mode picks where the lower value comes from. In key-store mode it is a key-store add counter, supplied on its own input. In IPsec mode it is the association's packet sequence number, which arrives with the request. In PSP mode it is a master timer that runs freely inside the block.

The block keeps the last value it issued for each mode. It releases an IV only when the new value is strictly greater than that record. In key-store and PSP modes it holds the response back and re-samples the source each cycle until the value has moved past the record. In IPsec mode a sequence number that has not moved forward means the 64-bit counter has wrapped. The block then answers at once with a deactivation flag and no IV.

Requests and responses each travel on a valid/ready channel, and only one request is in flight at a time. A requester may hold `req_valid` as long as it likes. A request is taken on a rising clock edge where both `req_valid` and `req_ready` are high. A response is held, unchanged, until a rising clock edge where both `iv_valid` and `iv_ready` are high. The consumer may hold `iv_ready` low for any number of cycles.

Top module: `gcm_nonce_gate`

## Requirements
- R1: `req_mode` is encoded as 0 for key-store, 1 for IPsec and 2 for PSP, and the code 3 acts as key-store. `iv_mode` reports the mode of the held response. `iv_data[95:64]` is the request's prefix and `iv_data[63:0]` is the chosen 64-bit value.
- R2: In key-store mode the value is `add_count`, sampled on the edge where the request is accepted. It is sampled again on every edge while the response is stalled.
- R3: In IPsec mode the value is the `req_seq` presented with the request.
- R4: In PSP mode the value is an internal 64-bit timer. The timer is zero at reset, adds one every clock and wraps at 2^64. It is sampled at acceptance and again on every stalled edge.
- R5: A non-flagged response is offered only when its value is strictly greater than the last non-flagged value issued in the same mode. Until then `iv_valid` stays low. The per-mode record is zero after reset, so a value of zero is never issued.
- R6: An IPsec request whose `req_seq` is less than or equal to the last issued IPsec value is answered without stalling. The answer has `iv_kill` = 1 and `iv_data` all zero, and the IPsec record is left unchanged.
- R7: Key-store and PSP responses never carry `iv_kill`. A key-store counter that wraps to a smaller value only stalls.
- R8: While `iv_valid` is high and `iv_ready` is low, `iv_data`, `iv_mode` and `iv_kill` hold their values on the next cycle.
- R9: `req_ready` is high when no response is held, or when the held response completes its handshake in that same cycle. A request taken in the handshake cycle is compared against a record that already includes the response just issued.
- R10: After reset `iv_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 2 | Mode code (R1) |
| req_prefix | input | 32 | Salt or SPI placed in the upper IV bits |
| req_seq | input | 64 | IPsec packet sequence number |
| add_count | input | 64 | Key-store add counter |
| iv_valid | output | 1 | Response offered |
| iv_ready | input | 1 | Consumer takes the response |
| iv_data | output | 96 | IV: prefix in bits 95:64, value in bits 63:0 |
| iv_mode | output | 2 | Mode of the held response |
| iv_kill | output | 1 | IPsec wrap detected, deactivate the association |

## Verification
Two things can happen in one cycle: a held IPsec response completes its handshake, and a new IPsec request is accepted. The new request's wrap test must then see the value that is being committed on that same edge. The bench sets this up by holding one IPsec response and raising `iv_ready` and `req_valid` together. In the first trial the new request repeats the held sequence number, and a kill flag is expected. In the second trial the new request uses the next sequence number, and a normal IV is expected.

// File: rtl/nonce_pkg.sv
package nonce_pkg;
  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 3;

  typedef enum logic [MODE_W-1:0] {
    NM_KEYSTORE = 2'd0,
    NM_IPSEC    = 2'd1,
    NM_PSP      = 2'd2,
    NM_RSVD     = 2'd3
  } nonce_mode_e;

  // The reserved code behaves as key-store.
  function automatic nonce_mode_e fold_mode(input logic [MODE_W-1:0] m);
    if (m == 2'd3) return NM_KEYSTORE;
    return nonce_mode_e'(m);
  endfunction
endpackage

// File: rtl/nonce_timer.sv
module nonce_timer #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/nonce_history.sv
module nonce_history
  import nonce_pkg::*;
#(
  parameter int VAL_W = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  nonce_mode_e                       commit_mode,
  input  logic [VAL_W-1:0]                  commit_val,
  output logic [NUM_MODES-1:0][VAL_W-1:0]   hist
);
  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hist[g] <= '0;
      else if (commit && (commit_mode == nonce_mode_e'(MODE_W'(g))))
        hist[g] <= commit_val;
    end
  end
endmodule

// File: rtl/nonce_stage.sv
module nonce_stage
  import nonce_pkg::*;
#(
  parameter int PFX_W = 32,
  parameter int VAL_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  nonce_mode_e       take_mode,
  input  logic [PFX_W-1:0]  take_prefix,
  input  logic [VAL_W-1:0]  take_seq,
  input  logic              take_kill,
  input  logic [VAL_W-1:0]  live_add,
  input  logic [VAL_W-1:0]  live_timer,
  input  logic              open,
  input  logic              drain,
  output logic              held,
  output nonce_mode_e       held_mode,
  output logic [PFX_W-1:0]  held_prefix,
  output logic [VAL_W-1:0]  held_val,
  output logic              held_kill
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held        <= 1'b0;
      held_mode   <= NM_KEYSTORE;
      held_prefix <= '0;
      held_val    <= '0;
      held_kill   <= 1'b0;
    end else if (take) begin
      held        <= 1'b1;
      held_mode   <= take_mode;
      held_prefix <= take_prefix;
      held_kill   <= take_kill;
      unique case (take_mode)
        NM_IPSEC: held_val <= take_seq;
        NM_PSP:   held_val <= live_timer;
        default:  held_val <= live_add;
      endcase
    end else if (drain) begin
      held <= 1'b0;
    end else if (held && !open && held_mode != NM_IPSEC) begin
      held_val <= (held_mode == NM_PSP) ? live_timer : live_add;
    end
  end
endmodule

// File: rtl/gcm_nonce_gate.sv
module gcm_nonce_gate
  import nonce_pkg::*;
#(
  parameter int PFX_W = 32,
  parameter int VAL_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_mode,
  input  logic [PFX_W-1:0]       req_prefix,
  input  logic [VAL_W-1:0]       req_seq,
  input  logic [VAL_W-1:0]       add_count,
  output logic                   iv_valid,
  input  logic                   iv_ready,
  output logic [PFX_W+VAL_W-1:0] iv_data,
  output logic [1:0]             iv_mode,
  output logic                   iv_kill
);
  localparam int IV_W = PFX_W + VAL_W;

  logic [VAL_W-1:0]                 timer_now;
  logic [NUM_MODES-1:0][VAL_W-1:0]  hist;
  logic                             held, held_kill;
  nonce_mode_e                      held_mode, in_mode;
  logic [PFX_W-1:0]                 held_prefix;
  logic [VAL_W-1:0]                 held_val, prev_sel, ipsec_floor;
  logic                             fire, commit, take, take_kill;

  nonce_timer #(.W(VAL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .count(timer_now)
  );

  nonce_history #(.VAL_W(VAL_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .commit_mode(held_mode), .commit_val(held_val), .hist(hist)
  );

  always_comb begin
    unique case (held_mode)
      NM_IPSEC: prev_sel = hist[1];
      NM_PSP:   prev_sel = hist[2];
      default:  prev_sel = hist[0];
    endcase
  end

  assign iv_valid = held && (held_kill || (held_val > prev_sel));
  assign fire     = iv_valid && iv_ready;
  assign commit   = fire && !held_kill;

  // Wrap test sees the IPsec value committed on this same edge.
  assign in_mode     = fold_mode(req_mode);
  assign ipsec_floor = (commit && held_mode == NM_IPSEC) ? held_val : hist[1];
  assign take_kill   = (in_mode == NM_IPSEC) && (req_seq <= ipsec_floor);
  assign req_ready   = !held || fire;
  assign take        = req_valid && req_ready;

  nonce_stage #(.PFX_W(PFX_W), .VAL_W(VAL_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_mode(in_mode), .take_prefix(req_prefix),
    .take_seq(req_seq), .take_kill(take_kill),
    .live_add(add_count), .live_timer(timer_now),
    .open(iv_valid), .drain(fire),
    .held(held), .held_mode(held_mode), .held_prefix(held_prefix),
    .held_val(held_val), .held_kill(held_kill)
  );

  assign iv_data = held_kill ? {IV_W{1'b0}} : {held_prefix, held_val};
  assign iv_mode = held_mode;
  assign iv_kill = held_kill;
endmodule

// File: rtl/gcm_nonce_gate_chk.sv
module gcm_nonce_gate_chk #(
  parameter int PFX_W = 32,
  parameter int VAL_W = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   iv_valid,
  input logic                   iv_ready,
  input logic [PFX_W+VAL_W-1:0] iv_data,
  input logic [1:0]             iv_mode,
  input logic                   iv_kill
);
  logic [VAL_W-1:0] last_v [4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) last_v[i] <= '0;
    end else if (iv_valid && iv_ready && !iv_kill) begin
      last_v[iv_mode] <= iv_data[VAL_W-1:0];
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iv_valid && !iv_ready |=> iv_valid && $stable(iv_data) && $stable(iv_mode) && $stable(iv_kill));

  // R5
  strict_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iv_valid && !iv_kill |-> iv_data[VAL_W-1:0] > last_v[iv_mode]);

  // R6
  kill_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iv_valid && iv_kill |-> iv_data == '0);

  // R7
  kill_ipsec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iv_valid && iv_kill |-> iv_mode == 2'd1);
endmodule

bind gcm_nonce_gate gcm_nonce_gate_chk #(.PFX_W(PFX_W), .VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iv_valid(iv_valid), .iv_ready(iv_ready),
  .iv_data(iv_data), .iv_mode(iv_mode), .iv_kill(iv_kill)
);

// File: tb/gcm_nonce_gate_test.sv
module gcm_nonce_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] pfx;
    logic [63:0] val;
    logic        kill;
    logic [1:0]  emode;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd0, 32'hA5A5_0001, 64'd5,  1'b0, 2'd0},
    '{2'd1, 32'h1234_5678, 64'd1,  1'b0, 2'd1},
    '{2'd1, 32'h1234_5678, 64'd7,  1'b0, 2'd1},
    '{2'd1, 32'h1234_5678, 64'd7,  1'b1, 2'd1},
    '{2'd1, 32'h1234_5678, 64'd3,  1'b1, 2'd1},
    '{2'd0, 32'hA5A5_0002, 64'd9,  1'b0, 2'd0},
    '{2'd1, 32'hCAFE_0001, ONES,   1'b0, 2'd1},
    '{2'd1, 32'hCAFE_0001, 64'd8,  1'b1, 2'd1},
    '{2'd3, 32'hA5A5_0003, 64'd10, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_mode = 2'd0;
  logic [31:0] req_prefix = '0;
  logic [63:0] req_seq = '0;
  logic [63:0] add_count = '0;
  logic        iv_valid;
  logic        iv_ready = 1'b0;
  logic [95:0] iv_data;
  logic [1:0]  iv_mode;
  logic        iv_kill;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcm_nonce_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_prefix(req_prefix), .req_seq(req_seq),
    .add_count(add_count), .iv_valid(iv_valid), .iv_ready(iv_ready),
    .iv_data(iv_data), .iv_mode(iv_mode), .iv_kill(iv_kill)
  );

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; iv_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic issue(input logic [1:0] m, input logic [31:0] p, input logic [63:0] v);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_prefix = p;
    if (m == 2'd1) req_seq = v;
    else if (m != 2'd2) add_count = v;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_valid(input int lim, output bit got);
    got = iv_valid;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk);
      got = iv_valid;
    end
  endtask

  task automatic take();
    iv_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    iv_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    logic [63:0] p1, p2;
    logic [95:0] snap;

    do_reset();
    @(negedge clk);
    // R10 reset state
    chk(!iv_valid, "R10 iv_valid after reset", 96'(iv_valid), 96'd0);
    chk(req_ready, "R10 req_ready after reset", 96'(req_ready), 96'd1);

    // Table walk: R1 R2 R3 R6
    for (int k = 0; k < 9; k++) begin
      issue(VEC[k].mode, VEC[k].pfx, VEC[k].val);
      wait_valid(4, got);
      chk(got, $sformatf("R5 vector %0d offered", k), 96'(got), 96'd1);
      chk(iv_kill == VEC[k].kill, $sformatf("R6 vector %0d kill", k), 96'(iv_kill), 96'(VEC[k].kill));
      chk(iv_mode == VEC[k].emode, $sformatf("R1 vector %0d mode", k), 96'(iv_mode), 96'(VEC[k].emode));
      if (VEC[k].kill)
        chk(iv_data == '0, $sformatf("R6 vector %0d data", k), iv_data, 96'd0);
      else
        chk(iv_data == {VEC[k].pfx, VEC[k].val}, $sformatf("R1 R2 R3 vector %0d data", k),
            iv_data, {VEC[k].pfx, VEC[k].val});
      take();
    end

    // R5 R2: key-store value not above record (10) stalls, then re-sampled
    issue(2'd0, 32'h0000_BEEF, 64'd10);
    repeat (4) @(negedge clk);
    chk(!iv_valid, "R5 key-store equal value stalls", 96'(iv_valid), 96'd0);
    add_count = 64'd12;
    @(negedge clk);
    chk(iv_valid, "R2 key-store re-sample opens", 96'(iv_valid), 96'd1);
    chk(iv_data == {32'h0000_BEEF, 64'd12}, "R2 key-store re-sampled value", iv_data, {32'h0000_BEEF, 64'd12});
    take();

    // R7: key-store wrap only stalls
    issue(2'd0, 32'h0000_0001, ONES);
    wait_valid(4, got);
    chk(got && iv_data[63:0] == ONES, "R7 key-store all-ones issued", iv_data, {32'h1, ONES});
    take();
    issue(2'd0, 32'h0000_0001, 64'd0);
    repeat (5) @(negedge clk);
    chk(!iv_valid && !iv_kill, "R7 key-store wrap stalls without kill", {iv_valid, iv_kill}, 96'd0);
    chk(!req_ready, "R9 no second request while stalled", 96'(req_ready), 96'd0);

    do_reset();
    @(negedge clk);
    chk(!iv_valid && req_ready, "R10 reset clears stalled entry", {iv_valid, req_ready}, 96'd1);

    // R9: same-cycle handshake and acceptance, repeated sequence number
    issue(2'd1, 32'h0000_0AAA, 64'd20);
    iv_ready = 1'b1; req_valid = 1'b1; req_mode = 2'd1; req_seq = 64'd20;
    #1;
    chk(req_ready, "R9 req_ready during handshake", 96'(req_ready), 96'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; iv_ready = 1'b0;
    chk(iv_valid && iv_kill && iv_data == '0, "R9 R6 repeat seq in handshake cycle killed",
        {iv_valid, iv_kill, iv_data[93:0]}, {2'b11, 94'd0});
    take();
    issue(2'd1, 32'h0000_0AAA, 64'd21);
    iv_ready = 1'b1; req_valid = 1'b1; req_seq = 64'd22;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; iv_ready = 1'b0;
    chk(iv_valid && !iv_kill && iv_data == {32'h0000_0AAA, 64'd22}, "R9 next seq in handshake cycle issued",
        iv_data, {32'h0000_0AAA, 64'd22});
    take();

    // R4 R8: PSP timer value, rising, held stable under back-pressure
    issue(2'd2, 32'h5151_0001, 64'd0);
    wait_valid(4, got);
    p1 = iv_data[63:0];
    snap = iv_data;
    chk(got && !iv_kill && iv_mode == 2'd2 && p1 != 0, "R4 PSP first value issued", iv_data, {32'h5151_0001, p1});
    chk(iv_data[95:64] == 32'h5151_0001, "R1 PSP prefix", 96'(iv_data[95:64]), 96'h5151_0001);
    repeat (3) @(negedge clk);
    chk(iv_valid && iv_data == snap, "R8 PSP data held under back-pressure", iv_data, snap);
    take();
    issue(2'd2, 32'h5151_0002, 64'd0);
    wait_valid(4, got);
    p2 = iv_data[63:0];
    chk(got && p2 > p1 && (p2 - p1) < 64'd20, "R4 PSP timer advanced", 96'(p2), 96'(p1 + 64'd6));
    take();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule